// File: doc/BRIEF.md
# Rotating-Coefficient Complex MAC FIR Filter

This block is a complex-valued FIR filter that takes one complex sample per clock and returns one complex result per clock. It does not use a delay line of past samples. It holds an array of `NTAPS` complex multiply-accumulate lanes, and every lane sees the current input sample. The coefficient each lane multiplies by moves one lane per cycle. As a result, each lane builds one full output over `NTAPS` consecutive cycles and finishes exactly one cycle after the previous lane. A phase counter picks the lane that is finishing, and its sum goes to a registered output.

The coefficients are loaded before filtering through a serial port, one complex word per clock while `load_en` is high. Loading and filtering never happen in the same cycle. Any cycle with `load_en` high clears every accumulator and returns the rotation to its starting alignment. The next filtering cycle is therefore time zero of a new stream with an all-zero history.

A small controller has three states. `ST_IDLE` is the state after reset, before any coefficient load. `ST_LOAD` is the state while words shift in. `ST_RUN` is the state while filtering. The transitions are as follows. IDLE goes to LOAD on `load_en`. LOAD goes to RUN when `load_en` falls. RUN goes back to LOAD on `load_en`. IDLE otherwise stays in IDLE. Filtering happens in every cycle where `load_en` is low and the state is not IDLE.

Top module: `rot_cmac_fir`

## Requirements
- R1: While `rst_n` is low, `y_valid` is 0 and `y_re`/`y_im` are 0, and the controller is in ST_IDLE.
- R2: Coefficient words shift in while `load_en` is high. After exactly `NTAPS` load cycles, the first word shifted becomes h[0] and the last becomes h[NTAPS-1].
- R3: A cycle with `load_en` high performs no filtering. `y_valid` is 0 after that edge. All accumulators and the rotation return to the time-zero alignment.
- R4: Every filtering cycle accepts one sample. `y_valid` is 1 and the output for that sample appears one clock edge later (one register of latency).
- R5: Using complex multiplication (re = ar·br − ai·bi, im = ar·bi + ai·br), the output for the t-th sample after a load is y[t] = Σ_{j=0}^{min(t,NTAPS-1)} x[t−j]·h[j]. Samples before the load count as zero.
- R6: The outputs are full precision, `ACCW` = 2·DW+1+clog2(NTAPS) bits signed. No wrap occurs even when every sample and coefficient part is −32768.
- R7: After reset and before any load, samples applied with `load_en` low produce no output (`y_valid` stays 0).
- R8: Reloading in the middle of a stream discards all earlier history. The first output after the new load is x[0]·h[0] of the new set.
- R9: In filtering cycle t, lane k uses h[(k−t) mod NTAPS]. Exactly one lane holds index 0 at any time, and it is the lane the output selector points at.
- R10: The result stays exact in steady state (t ≥ NTAPS), after every lane has wrapped and restarted its sum at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | High: shift one coefficient word in and hold the filter at time zero |
| coef_re_in | input | DW | Real part of the serial coefficient word |
| coef_im_in | input | DW | Imaginary part of the serial coefficient word |
| x_re | input | DW | Real part of the input sample, signed |
| x_im | input | DW | Imaginary part of the input sample, signed |
| y_re | output | ACCW | Real part of the filtered output, signed |
| y_im | output | ACCW | Imaginary part of the filtered output, signed |
| y_valid | output | 1 | High when y_re/y_im carry a result for the previous cycle's sample |

## Verification
An impulse after a load must return the coefficients in order. A lane whose counter ran the wrong way, or a store that shifted the wrong way, would therefore return h reversed or shifted. A long stream past NTAPS samples checks that each lane restarts its sum when its index reaches NTAPS−1. A lane that kept adding instead would leak the previous window into every output from t = NTAPS on. All-minimum operands drive the imaginary sums to their largest magnitude, which catches an accumulator one bit too narrow, and a reload in the middle of a stream catches stale history or a selector that was not realigned to lane 0.

// File: rtl/fir_pkg.sv
package fir_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } fir_state_e;
endpackage

// File: rtl/coef_store.sv
module coef_store #(
    parameter int NTAPS = 64,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic [DW-1:0]              in_re,
    input  logic [DW-1:0]              in_im,
    output logic [NTAPS-1:0][DW-1:0]   h_re,
    output logic [NTAPS-1:0][DW-1:0]   h_im
);
    // Words enter at the top slot and move toward slot 0, so the first
    // word pushed lands in slot 0 after NTAPS shifts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_re <= '0;
            h_im <= '0;
        end else if (shift_en) begin
            for (int k = 0; k < NTAPS - 1; k++) begin
                h_re[k] <= h_re[k+1];
                h_im[k] <= h_im[k+1];
            end
            h_re[NTAPS-1] <= in_re;
            h_im[NTAPS-1] <= in_im;
        end
    end
endmodule

// File: rtl/cplx_mul.sv
module cplx_mul #(
    parameter  int DW = 16,
    localparam int PW = 2 * DW,
    localparam int SW = PW + 1
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    output logic signed [SW-1:0] p_re,
    output logic signed [SW-1:0] p_im
);
    logic signed [PW-1:0] rr, ii, ri, ir;

    assign rr = a_re * b_re;
    assign ii = a_im * b_im;
    assign ri = a_re * b_im;
    assign ir = a_im * b_re;

    // Real part: subtraction folded into one adder as invert plus carry-in.
    assign p_re = {rr[PW-1], rr} + ~{ii[PW-1], ii} + {{PW{1'b0}}, 1'b1};
    assign p_im = {ri[PW-1], ri} + {ir[PW-1], ir};
endmodule

// File: rtl/mac_lane.sv
module mac_lane #(
    parameter  int NTAPS = 64,
    parameter  int DW    = 16,
    parameter  int LANE  = 0,
    localparam int IW    = $clog2(NTAPS),
    localparam int SW    = 2 * DW + 1,
    localparam int ACCW  = SW + IW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en,
    input  logic                   align,
    input  logic signed [DW-1:0]   x_re,
    input  logic signed [DW-1:0]   x_im,
    input  logic signed [DW-1:0]   h_re,
    input  logic signed [DW-1:0]   h_im,
    output logic [IW-1:0]          idx,
    output logic signed [ACCW-1:0] sum_re,
    output logic signed [ACCW-1:0] sum_im,
    output logic                   done
);
    localparam logic [IW-1:0] START = IW'(LANE);
    localparam logic [IW-1:0] LAST  = IW'(NTAPS - 1);

    logic signed [SW-1:0]   p_re, p_im;
    logic signed [ACCW-1:0] acc_re, acc_im;
    logic signed [ACCW-1:0] base_re, base_im;

    cplx_mul #(.DW(DW)) u_mul (
        .a_re(x_re), .a_im(x_im), .b_re(h_re), .b_im(h_im),
        .p_re(p_re), .p_im(p_im)
    );

    // Index LAST starts a fresh window: the old sum is dropped, not added.
    assign base_re = (idx == LAST) ? '0 : acc_re;
    assign base_im = (idx == LAST) ? '0 : acc_im;
    assign sum_re  = base_re + {{IW{p_re[SW-1]}}, p_re};
    assign sum_im  = base_im + {{IW{p_im[SW-1]}}, p_im};
    assign done    = (idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= START;
            acc_re <= '0;
            acc_im <= '0;
        end else if (align) begin
            idx    <= START;
            acc_re <= '0;
            acc_im <= '0;
        end else if (run_en) begin
            idx    <= (idx == '0) ? LAST : idx - 1'b1;
            acc_re <= sum_re;
            acc_im <= sum_im;
        end
    end
endmodule

// File: rtl/rot_cmac_fir.sv
module rot_cmac_fir
    import fir_pkg::*;
#(
    parameter  int NTAPS = 64,
    parameter  int DW    = 16,
    localparam int IW    = $clog2(NTAPS),
    localparam int ACCW  = 2 * DW + 1 + IW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [DW-1:0]          coef_re_in,
    input  logic [DW-1:0]          coef_im_in,
    input  logic signed [DW-1:0]   x_re,
    input  logic signed [DW-1:0]   x_im,
    output logic signed [ACCW-1:0] y_re,
    output logic signed [ACCW-1:0] y_im,
    output logic                   y_valid
);
    fir_state_e state_q, state_d;
    logic       shift_en, align, run_en;
    logic [IW-1:0] sel_q;

    logic [NTAPS-1:0][DW-1:0] h_re, h_im;
    logic [IW-1:0]            lane_idx  [NTAPS];
    logic signed [DW-1:0]     lane_h_re [NTAPS];
    logic signed [DW-1:0]     lane_h_im [NTAPS];
    logic signed [ACCW-1:0]   lane_s_re [NTAPS];
    logic signed [ACCW-1:0]   lane_s_im [NTAPS];
    logic [NTAPS-1:0]         lane_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_en) state_d = ST_LOAD;
            ST_LOAD: if (!load_en) state_d = ST_RUN;
            ST_RUN:  if (load_en) state_d = ST_LOAD;
            default: state_d = ST_IDLE;
        endcase
    end

    // Controls derived from state
    always_comb begin
        shift_en = load_en;
        align    = load_en;
        run_en   = !load_en && (state_q != ST_IDLE);
    end

    coef_store #(.NTAPS(NTAPS), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .in_re(coef_re_in), .in_im(coef_im_in),
        .h_re(h_re), .h_im(h_im)
    );

    for (genvar k = 0; k < NTAPS; k++) begin : g_lane
        assign lane_h_re[k] = h_re[lane_idx[k]];
        assign lane_h_im[k] = h_im[lane_idx[k]];

        mac_lane #(.NTAPS(NTAPS), .DW(DW), .LANE(k)) u_lane (
            .clk(clk), .rst_n(rst_n), .run_en(run_en), .align(align),
            .x_re(x_re), .x_im(x_im),
            .h_re(lane_h_re[k]), .h_im(lane_h_im[k]),
            .idx(lane_idx[k]),
            .sum_re(lane_s_re[k]), .sum_im(lane_s_im[k]),
            .done(lane_done[k])
        );
    end

    // Output phase: points at the lane whose coefficient index is zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (align)  sel_q <= '0;
        else if (run_en) sel_q <= (sel_q == IW'(NTAPS - 1)) ? '0 : sel_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_re    <= '0;
            y_im    <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= run_en;
            if (run_en) begin
                y_re <= lane_s_re[sel_q];
                y_im <= lane_s_im[sel_q];
            end
        end
    end
endmodule

// File: rtl/rot_cmac_fir_checker.sv
module rot_cmac_fir_checker
    import fir_pkg::*;
#(
    parameter int NTAPS = 64,
    parameter int IW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input fir_state_e       state,
    input logic [IW-1:0]    sel,
    input logic [NTAPS-1:0] done,
    input logic             y_valid
);
    // R9: exactly one lane finishes at any time
    assert_one_finisher_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(done) == 1);

    // R9: the output phase points at the finishing lane
    assert_sel_on_finisher_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done[sel]);

    // R3: a load cycle realigns to time zero and yields no output
    assert_load_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (sel == '0) && done[0] && !y_valid);

    // R7: no output before the first load
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !load_en) |=> !y_valid);

    // R4: each filtering cycle produces an output one edge later
    assert_stream_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !load_en) |=> y_valid);
endmodule

bind rot_cmac_fir rot_cmac_fir_checker #(.NTAPS(NTAPS), .IW(IW)) u_checker (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .state(state_q),
    .sel(sel_q), .done(lane_done), .y_valid(y_valid)
);

// File: tb/test_rot_cmac_fir.sv
module test_rot_cmac_fir;
    localparam int N          = 8;
    localparam int DW         = 16;
    localparam int IW         = $clog2(N);
    localparam int ACCW       = 2 * DW + 1 + IW;
    localparam int CLK_PERIOD = 10;

    logic                   clk, rst_n, load_en;
    logic [DW-1:0]          coef_re_in, coef_im_in;
    logic signed [DW-1:0]   x_re, x_im;
    logic signed [ACCW-1:0] y_re, y_im;
    logic                   y_valid;

    int checks = 0;
    int fails  = 0;

    longint h_re_m [N];
    longint h_im_m [N];
    longint hx_re  [N];
    longint hx_im  [N];

    rot_cmac_fir #(.NTAPS(N), .DW(DW)) i_rot_cmac_fir (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .coef_re_in(coef_re_in), .coef_im_in(coef_im_in),
        .x_re(x_re), .x_im(x_im),
        .y_re(y_re), .y_im(y_im), .y_valid(y_valid)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pv(input int i, input int salt);
        int v;
        v = (i * 7919 + salt * 104729 + 12345) % 65536;
        return v[DW-1:0];
    endfunction

    task automatic clear_history();
        for (int j = 0; j < N; j++) begin
            hx_re[j] = 0;
            hx_im[j] = 0;
        end
    endtask

    // Push the model's coefficients h[0]..h[N-1] in that order (R2).
    task automatic load_set();
        for (int i = 0; i < N; i++) begin
            load_en    = 1'b1;
            coef_re_in = h_re_m[i][DW-1:0];
            coef_im_in = h_im_m[i][DW-1:0];
            @(negedge clk);
            check("R3", "y_valid during load", longint'(y_valid), 0);
        end
        load_en = 1'b0;
        clear_history();
    endtask

    // One filtering cycle: drive sample, compare output one edge later.
    task automatic step(input string req, input logic [DW-1:0] xr, input logic [DW-1:0] xi);
        longint er, ei;
        load_en = 1'b0;
        x_re    = xr;
        x_im    = xi;
        for (int j = N - 1; j > 0; j--) begin
            hx_re[j] = hx_re[j-1];
            hx_im[j] = hx_im[j-1];
        end
        hx_re[0] = longint'($signed(xr));
        hx_im[0] = longint'($signed(xi));
        er = 0;
        ei = 0;
        for (int j = 0; j < N; j++) begin
            er += hx_re[j] * h_re_m[j] - hx_im[j] * h_im_m[j];
            ei += hx_re[j] * h_im_m[j] + hx_im[j] * h_re_m[j];
        end
        @(negedge clk);
        check("R4", "y_valid after sample", longint'(y_valid), 1);
        check(req, "y_re", longint'(y_re), er);
        check(req, "y_im", longint'(y_im), ei);
    endtask

    task automatic set_coefs(input int salt);
        for (int i = 0; i < N; i++) begin
            h_re_m[i] = longint'($signed(pv(i, salt)));
            h_im_m[i] = longint'($signed(pv(i + 3, salt + 7)));
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        load_en = 1'b0;
        coef_re_in = '0;
        coef_im_in = '0;
        x_re = '0;
        x_im = '0;
        repeat (3) @(negedge clk);
        check("R1", "y_valid in reset", longint'(y_valid), 0);
        check("R1", "y_re in reset", longint'(y_re), 0);
        check("R1", "y_im in reset", longint'(y_im), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_idle();
        for (int i = 0; i < 4; i++) begin
            load_en = 1'b0;
            x_re = pv(i, 5);
            x_im = pv(i, 9);
            @(negedge clk);
            check("R7", "y_valid before any load", longint'(y_valid), 0);
        end
    endtask

    task automatic test_impulse();
        set_coefs(1);
        load_set();
        step("R2", 16'd1, 16'd0);
        for (int i = 0; i < N + 2; i++) step("R2", 16'd0, 16'd0);
        // Imaginary impulse: y = j*h, exercises the invert-plus-carry path
        load_set();
        step("R5", 16'd0, 16'd1);
        for (int i = 0; i < N; i++) step("R5", 16'd0, 16'd0);
    endtask

    task automatic test_stream();
        // R9 rotation and R10 wrap: run three full windows of mixed data
        set_coefs(2);
        load_set();
        for (int i = 0; i < 3 * N; i++) step(i < N ? "R5" : "R10", pv(i, 11), pv(i, 13));
    endtask

    task automatic test_extreme();
        for (int i = 0; i < N; i++) begin
            h_re_m[i] = -32768;
            h_im_m[i] = -32768;
        end
        load_set();
        for (int i = 0; i < N + 2; i++) step("R6", 16'h8000, 16'h8000);
        for (int i = 0; i < 2; i++) step("R6", 16'h7FFF, 16'h8000);
    endtask

    task automatic test_reload();
        set_coefs(3);
        load_set();
        for (int i = 0; i < 5; i++) step("R5", pv(i, 17), pv(i, 19));
        set_coefs(4);
        load_set();
        step("R8", pv(0, 23), pv(0, 29));
        for (int i = 1; i < 2 * N; i++) step("R8", pv(i, 23), pv(i, 29));
    endtask

    initial begin
        test_reset();
        test_idle();
        test_impulse();
        test_stream();
        test_extreme();
        test_reload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule